// File: doc/BRIEF.md
# Programmable Delay Timer Bank

A bank of four independent delay timers for power-supply sequencing logic. Each timer counts enable events while its start level is held high. Its done output rises once a programmed number of events has been counted, and it stays high until start is released. The events come from either a free-running 4 µs system tick or a slow external clock. Each timer picks one of sixteen durations, from 32 µs to 512 ms on the internal tick. Because start is a level, control logic can release a timer and arm it again under another condition.

A shared prescaler turns the system tick into a logic-clock enable. The enable either passes every tick through or keeps only one tick in 125, which gives 2 kHz from 250 kHz. Everything runs in one clock domain. The external clock is used only through a synchroniser and an edge detector.

Top module: `dly_timer_bank`

## Requirements
- R1: The four timers are independent: each has its own start bit, 4-bit code (bits 4k+3..4k of the code bus) and source select, and the progress of one never changes the timing of another.
- R2: The code sets the terminal count N. Codes 0 to 13 give N = 8·2^code. Code 14 gives N = 96000. Code 15 gives N = 128000. The count increments on each edge where start is high and an enable is present. Done rises on the edge that consumes the N-th enable.
- R3: With the internal source selected (source bit 0), only edges with the tick input high advance the count. With the tick held low, the timer does not progress.
- R4: Once done is high it stays high for as long as start stays high, and counting stops.
- R5: An edge that samples start low clears the count and the done output. The next run counts from zero again.
- R6: The code is captured on the first edge of a run. A code change during a run has no effect until start has gone low and high again.
- R7: With the external source selected (source bit 1), the tick is ignored. The external clock passes through two synchronising flops. A rising level first sampled on edge e advances the count on edge e+2.
- R8: With the divide select at 0, the logic enable equals the tick. With it at 1, the enable is high only on every 125th tick counted since reset, first on the 125th.
- R9: Synchronous reset clears all counts, drives all done outputs low and restarts the prescaler. A timer whose start is still high counts from zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Internal 4 µs tick enable, one cycle wide |
| ext_clk_i | input | 1 | Slow external clock, asynchronous |
| div_sel_i | input | 1 | Prescaler select: 0 pass tick, 1 divide by 125 |
| start_i | input | 4 | Run level per timer |
| src_ext_i | input | 4 | Source per timer: 0 tick, 1 external clock |
| dur_sel_i | input | 16 | Duration code, 4 bits per timer |
| done_o | output | 4 | Timer expired, held while start stays high |
| logic_en_o | output | 1 | Prescaled logic-clock enable |

## Verification
The tick is driven high every cycle. A start that is first sampled on edge s therefore gives a done rise on edge s+N-1. The bench pushes that edge number into a per-timer queue in the same cycle it drives start. In the external-clock case the due edge is two edges after the eighth rising level is first sampled. In the gapped-tick case it is the edge that samples the eighth tick. A monitor samples on falling edges and compares each done rise with the queued edge. Early, late, missing and unexpected rises all fail, for every code, with the four timers running in parallel. The done clear is due one edge after start falls. The prescaler pulses are due 124 and 249 edges after the reset edge. Each of these is sampled at exactly that cycle.

// File: rtl/dt_pkg.sv
package dt_pkg;
  // Terminal count for a duration code: doubling from base, the last two codes
  // pinned to three quarters of the top and the top itself.
  function automatic int unsigned dt_term_count(input int unsigned code,
                                                input int unsigned ncodes,
                                                input int unsigned base,
                                                input int unsigned top);
    if (code == ncodes - 1) return top;
    if (code == ncodes - 2) return top - top / 4;
    return base << code;
  endfunction
endpackage

// File: rtl/dt_edge_sync.sv
module dt_edge_sync (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;
endmodule

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int DIV = 125,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic div_sel_i,
  output logic en_o
);
  logic [PW-1:0] phase_q;
  logic          wrap;

  assign wrap = (phase_q == PW'(DIV - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i)       phase_q <= '0;
    else if (tick_i) phase_q <= wrap ? '0 : phase_q + 1'b1;
  end

  assign en_o = tick_i & (~div_sel_i | wrap);
endmodule

// File: rtl/dt_channel.sv
module dt_channel
  import dt_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int BASE_TICKS = 8,
  parameter int MAX_TICKS  = 128000,
  localparam int NCODES    = 2 ** CODE_W,
  localparam int CNT_W     = $clog2(MAX_TICKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, term_q, term_live, term_eff;
  logic             run_q;

  assign term_live = CNT_W'(dt_term_count(int'(code_i), NCODES, BASE_TICKS, MAX_TICKS));
  assign term_eff  = run_q ? term_q : term_live;
  assign cnt_inc   = cnt_q + 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      term_q <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else if (!start_i) begin
      cnt_q  <= '0;
      term_q <= term_live;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      term_q <= term_eff;
      if (en_i && !done_o) begin
        cnt_q <= cnt_inc;
        if (cnt_inc == term_eff) done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dly_timer_bank.sv
module dly_timer_bank #(
  parameter int NUM_TMR    = 4,
  parameter int CODE_W     = 4,
  parameter int BASE_TICKS = 8,
  parameter int MAX_TICKS  = 128000,
  parameter int PRESC_DIV  = 125
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       tick_i,
  input  logic                       ext_clk_i,
  input  logic                       div_sel_i,
  input  logic [NUM_TMR-1:0]         start_i,
  input  logic [NUM_TMR-1:0]         src_ext_i,
  input  logic [NUM_TMR*CODE_W-1:0]  dur_sel_i,
  output logic [NUM_TMR-1:0]         done_o,
  output logic                       logic_en_o
);
  logic               ext_rise_w;
  logic [NUM_TMR-1:0] cnt_en_w;

  dt_edge_sync u_ext_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .async_i(ext_clk_i),
    .rise_o (ext_rise_w)
  );

  dt_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_i   (tick_i),
    .div_sel_i(div_sel_i),
    .en_o     (logic_en_o)
  );

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    assign cnt_en_w[k] = src_ext_i[k] ? ext_rise_w : tick_i;

    dt_channel #(
      .CODE_W    (CODE_W),
      .BASE_TICKS(BASE_TICKS),
      .MAX_TICKS (MAX_TICKS)
    ) u_chan (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .start_i(start_i[k]),
      .en_i   (cnt_en_w[k]),
      .code_i (dur_sel_i[k*CODE_W +: CODE_W]),
      .done_o (done_o[k])
    );
  end
endmodule

// File: rtl/dly_timer_bank_chk.sv
module dly_timer_bank_chk #(
  parameter int NUM_TMR = 4
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               tick_i,
  input logic               div_sel_i,
  input logic               logic_en_o,
  input logic [NUM_TMR-1:0] start_i,
  input logic [NUM_TMR-1:0] done_o,
  input logic [NUM_TMR-1:0] cnt_en
);
  // R8
  presc_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    logic_en_o |-> tick_i);

  // R8
  presc_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (div_sel_i && logic_en_o) |=> (!logic_en_o || !div_sel_i));

  // R9
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (done_o == '0));

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_chk
    // R5
    idle_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !start_i[k] |=> !done_o[k]);

    // R4
    done_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (start_i[k] && done_o[k]) |=> done_o[k]);

    // R3
    rise_needs_en_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(done_o[k]) |-> $past(cnt_en[k]));
  end
endmodule

bind dly_timer_bank dly_timer_bank_chk #(.NUM_TMR(NUM_TMR)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .tick_i    (tick_i),
  .div_sel_i (div_sel_i),
  .logic_en_o(logic_en_o),
  .start_i   (start_i),
  .done_o    (done_o),
  .cnt_en    (cnt_en_w)
);

// File: tb/dly_timer_bank_bench.sv
module dly_timer_bank_bench;
  localparam int NT = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, tick, ext, dsel, len;
  logic [NT-1:0] start, src, done;
  logic [NT*4-1:0] dur;

  int unsigned cyc = 0;
  int total = 0, bad = 0;
  int unsigned exp_q [NT][$];
  logic [NT-1:0] prev_done = '0;

  dly_timer_bank u_dly_timer_bank (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .ext_clk_i(ext), .div_sel_i(dsel),
    .start_i(start), .src_ext_i(src), .dur_sel_i(dur),
    .done_o(done), .logic_en_o(len)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int unsigned ticks_for(input int code);
    int unsigned t;
    if (code == 15) return 128000;
    if (code == 14) return 96000;
    t = 8;
    for (int i = 0; i < code; i++) t = t * 2;
    return t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every done rise must match the queued edge number
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < NT; k++) begin
        if (done[k] && !prev_done[k]) begin
          if (exp_q[k].size() == 0) check($sformatf("R2 unexpected rise t%0d", k), 1, 0);
          else check($sformatf("R2 rise edge t%0d", k), int'(cyc), int'(exp_q[k].pop_front()));
        end
      end
    end
    prev_done = rst ? '0 : done;
  end

  task automatic nstep(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input int k, input int code);
    dur[k*4 +: 4] = 4'(code);
    start[k] = 1'b1;
  endtask

  task automatic launch(input int k, input int code);
    arm(k, code);
    exp_q[k].push_back(cyc + ticks_for(code));
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 195000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    int c0, first, second, npulse, cnt, c8;
    rst = 1; tick = 0; ext = 0; dsel = 0; start = '0; src = '0; dur = '0;
    nstep(3);
    check("R9 done after reset", int'(done), 0);
    check("R9 logic_en after reset", int'(len), 0);

    // R8 divide by 125 from reset
    rst = 1; tick = 1; dsel = 1;
    nstep(1);
    rst = 0; c0 = int'(cyc);
    first = -1; second = -1; npulse = 0;
    for (int i = 0; i < 260; i++) begin
      if (len) begin
        npulse++;
        if (first < 0) first = int'(cyc) - c0;
        else if (second < 0) second = int'(cyc) - c0;
      end
      nstep(1);
    end
    check("R8 first pulse", first, 124);
    check("R8 second pulse", second, 249);
    check("R8 pulse count", npulse, 2);
    dsel = 0;
    for (int i = 0; i < 6; i++) begin
      tick = i[0];
      #1 check("R8 pass-through", int'(len), int'(tick));
      nstep(1);
    end
    tick = 1;
    nstep(1);

    // R1 R2 parallel short codes, R4 hold, R5 clear
    for (int b = 0; b < 3; b++) begin
      for (int k = 0; k < NT; k++) launch(k, b * 4 + k);
      nstep(int'(ticks_for(b * 4 + 3)) + 4);
      check("R1 all done", int'(done), 15);
      nstep(20);
      check("R4 done held", int'(done), 15);
      start = '0;
      nstep(1);
      check("R5 done cleared", int'(done), 0);
    end

    // R5 early release restarts from zero
    arm(1, 2);
    nstep(20);
    start[1] = 0;
    nstep(1);
    launch(1, 2);
    nstep(40);
    check("R5 restart done", int'(done[1]), 1);
    start[1] = 0;
    nstep(1);

    // R6 code change mid-run ignored
    launch(2, 3);
    nstep(10);
    dur[2*4 +: 4] = 4'd0;
    nstep(60);
    check("R6 done after old code", int'(done[2]), 1);
    start[2] = 0;
    nstep(1);
    launch(2, 0);
    nstep(12);
    check("R6 new code after restart", int'(done[2]), 1);
    start[2] = 0;
    nstep(1);

    // R3 tick held low: no progress
    tick = 0;
    arm(0, 0);
    nstep(30);
    check("R3 no tick no done", int'(done[0]), 0);
    tick = 1;
    exp_q[0].push_back(cyc + 8);
    nstep(12);
    check("R3 done after ticks", int'(done[0]), 1);
    start[0] = 0;
    nstep(1);

    // R3 gapped tick
    arm(3, 0);
    tick = 1; cnt = 1;
    while (cnt < 8) begin
      nstep(1);
      tick = ~tick;
      if (tick) cnt++;
    end
    exp_q[3].push_back(cyc + 1);
    nstep(1);
    tick = 1;
    nstep(3);
    check("R3 gapped done", int'(done[3]), 1);
    start[3] = 0;
    nstep(1);

    // R7 external source, tick ignored
    src[1] = 1;
    arm(1, 0);
    nstep(2);
    for (int e = 1; e <= 8; e++) begin
      ext = 1;
      if (e == 8) begin
        c8 = int'(cyc);
        exp_q[1].push_back(cyc + 3);
      end
      nstep(2);
      ext = 0;
      nstep(2);
    end
    check("R7 ext done", int'(done[1]), 1);
    start[1] = 0; src[1] = 0;
    nstep(4);

    // R9 reset while done high, restart from zero
    launch(0, 0);
    nstep(12);
    rst = 1;
    nstep(1);
    check("R9 reset clears done", int'(done[0]), 0);
    rst = 0;
    exp_q[0].push_back(cyc + 8);
    nstep(12);
    check("R9 restart after reset", int'(done[0]), 1);
    start = '0;
    nstep(1);

    // R2 long codes in parallel
    for (int k = 0; k < NT; k++) launch(k, 12 + k);
    nstep(128004);
    check("R2 long codes done", int'(done), 15);
    start = '0;
    nstep(2);

    for (int k = 0; k < NT; k++)
      check($sformatf("R2 missing rise t%0d", k), exp_q[k].size(), 0);
    if (c8 < 0) check("R7 edge", c8, 0);
    finish_run();
  end
endmodule